// File: doc/BRIEF.md
# Synchronous Dual-Port Word RAM with Input-Register Hold

This block is a true two-port random-access memory of 4096 words, each 9 bits wide. Two fully independent ports, each with its own clock and reset, can read and write any word. Every input of a port is taken into a register on the rising edge of that port's clock. The address and write-data registers of a port can be frozen by an active-low clock-enable pin, without gating the clock. A held address or data word is then reused by the operations that follow.

A port is selected by an active-low chip-enable pin. When the port is selected, a read/write pin picks the operation: high reads, low writes. A write issued at one edge is committed to the array at the next edge of the same clock. A read returns the word at the registered address one edge after that address was taken in. Pad tri-stating is modelled as a data bus plus a drive flag. The drive flag comes from a registered read-selected state and is gated combinationally by an active-low output-enable pin. When chip enable is high, the port is deselected and the drive flag is released.

Internally each port owns a private storage bank, and every word is the XOR of the two banks. This gives each bank a single writer and a single clock. Both ports still see one shared memory.

Top module: `dpram_dual_sync`

## Requirements
- R1: The memory holds 4096 words of 9 bits. Port A and port B run on independent clocks, and either port can write any word and read any word.
- R2: Chip enable and read/write are taken into the port's registers at every rising edge of that port's clock, whatever the clock-enable level. The captured command takes effect at the next edge.
- R3: If clock_enable_n is low at an edge, the address and write-data registers load the pin values. If it is high, they keep their contents, and a read or write commanded at that edge uses the held address and held data.
- R4: If ce_n is high at an edge, that command writes nothing. The drive flag is low after the second edge counted from it.
- R5: If ce_n is low and rw is low at edge k, the registered data is stored at the registered address at edge k+1. A read captured at edge k+1 or later returns the new word.
- R6: If ce_n is low and rw is high at edge k, rd_data carries the word at the registered address after edge k+1. The drive flag rises at edge k+1, not at edge k, provided oe_n is low.
- R7: oe_n acts without a clock. While oe_n is high the drive flag is low. While oe_n is low the drive flag shows the registered read-selected state, and changes in the same cycle that oe_n changes.
- R8: While a port's rst_n is low, its drive flag is low, its captured command is deselect, and its address and data registers are zero.
- R9: A word written by one port is returned by the other port once the write has been committed. Writes to the same address by both ports at coincident edges leave that word undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock, rising edge active |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_clken_n | input | 1 | Port A address/data register load enable, active low |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_rw | input | 1 | Port A operation: 1 read, 0 write |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 9 | Port A write data |
| a_rdata | output | 9 | Port A read data, meaningful while a_drive is high |
| a_drive | output | 1 | Port A pad drive flag |
| b_clk | input | 1 | Port B clock, rising edge active |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_clken_n | input | 1 | Port B address/data register load enable, active low |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_rw | input | 1 | Port B operation: 1 read, 0 write |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 9 | Port B write data |
| b_rdata | output | 9 | Port B read data, meaningful while b_drive is high |
| b_drive | output | 1 | Port B pad drive flag |

## Verification
A wrong bank word shows up as a wrong rd_data two edges after a read command for that address. Because a word is the XOR of two banks, a fault in either bank corrupts reads on both ports. A held register that reloads when it should not, or that fails to reload, sends the next read or write to the wrong address, and the bench catches it by reading back both the intended word and a neighbouring word. A fault in the read-selected state or in the output-enable gating shows on the drive flag within one edge, or, for the gating, in the same cycle without any edge.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic ce_n, input logic rw);
    if (ce_n)     return OP_IDLE;
    else if (!rw) return OP_WRITE;
    else          return OP_READ;
  endfunction

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clken_n,
  input  logic          ce_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output port_op_e      op_q
);

  // Address/data registers stall on clken_n; the command register never stalls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      op_q    <= OP_IDLE;
    end else begin
      if (!clken_n) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      op_q <= decode_op(ce_n, rw);
    end
  end

  assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clken_n) |-> ($stable(addr_q) && $stable(wdata_q)));

  assert_load_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clken_n |=> (addr_q == $past(addr)) && (wdata_q == $past(wdata)));

endmodule

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

  assert_bank_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dpram_readout.sv
module dpram_readout #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [DW-1:0] word,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          drive
);

  logic rd_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_flag <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_flag <= rd_go;
      if (rd_go) rd_data <= word;
    end
  end

  assign drive = rd_flag & ~oe_n;

  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive);

endmodule

// File: rtl/dpram_dual_sync.sv
module dpram_dual_sync
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_clken_n,
  input  logic          a_ce_n,
  input  logic          a_rw,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_drive,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_clken_n,
  input  logic          b_ce_n,
  input  logic          b_rw,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_drive
);

  localparam int NP = 2;

  logic          clk_v     [NP];
  logic          rst_v     [NP];
  logic          clken_v   [NP];
  logic          ce_v      [NP];
  logic          rw_v      [NP];
  logic          oe_v      [NP];
  logic [AW-1:0] addr_v    [NP];
  logic [DW-1:0] wdata_v   [NP];
  logic [DW-1:0] rdata_v   [NP];
  logic          drive_v   [NP];

  logic [AW-1:0] addr_q    [NP];
  logic [DW-1:0] wdata_q   [NP];
  port_op_e      op_q      [NP];
  logic [DW-1:0] bank_rd   [NP][NP];  // [bank][port address]
  logic [DW-1:0] bank_wd   [NP];
  logic [DW-1:0] word_v    [NP];

  assign clk_v   = '{a_clk, b_clk};
  assign rst_v   = '{a_rst_n, b_rst_n};
  assign clken_v = '{a_clken_n, b_clken_n};
  assign ce_v    = '{a_ce_n, b_ce_n};
  assign rw_v    = '{a_rw, b_rw};
  assign oe_v    = '{a_oe_n, b_oe_n};
  assign addr_v  = '{a_addr, b_addr};
  assign wdata_v = '{a_wdata, b_wdata};

  assign a_rdata = rdata_v[0];
  assign a_drive = drive_v[0];
  assign b_rdata = rdata_v[1];
  assign b_drive = drive_v[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int OTHER = NP - 1 - p;

    dpram_port_ctl #(.AW(AW), .DW(DW)) u_ctl (
      .clk     (clk_v[p]),
      .rst_n   (rst_v[p]),
      .clken_n (clken_v[p]),
      .ce_n    (ce_v[p]),
      .rw      (rw_v[p]),
      .addr    (addr_v[p]),
      .wdata   (wdata_v[p]),
      .addr_q  (addr_q[p]),
      .wdata_q (wdata_q[p]),
      .op_q    (op_q[p])
    );

    // Bank p stores data XOR the other bank, so the XOR of both banks is the word.
    assign bank_wd[p] = wdata_q[p] ^ bank_rd[OTHER][p];

    dpram_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk    (clk_v[p]),
      .rst_n  (rst_v[p]),
      .we     (op_q[p] == OP_WRITE),
      .waddr  (addr_q[p]),
      .wdata  (bank_wd[p]),
      .raddr0 (addr_q[0]),
      .raddr1 (addr_q[1]),
      .rdata0 (bank_rd[p][0]),
      .rdata1 (bank_rd[p][1])
    );

    assign word_v[p] = bank_rd[0][p] ^ bank_rd[1][p];

    dpram_readout #(.DW(DW)) u_out (
      .clk     (clk_v[p]),
      .rst_n   (rst_v[p]),
      .rd_go   (op_q[p] == OP_READ),
      .word    (word_v[p]),
      .oe_n    (oe_v[p]),
      .rd_data (rdata_v[p]),
      .drive   (drive_v[p])
    );

    // Edges seen since reset, saturating at 2, so two-deep history is valid.
    logic [1:0] age;
    always_ff @(posedge clk_v[p] or negedge rst_v[p]) begin
      if (!rst_v[p])     age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
    end

    assert_deselect_release_R4: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
      (age == 2'd2) && $past(ce_v[p], 2) |-> !drive_v[p]);

    assert_read_latency_R6: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
      (age == 2'd2) && !$past(ce_v[p], 2) && $past(rw_v[p], 2) && !oe_v[p] |-> drive_v[p]);
  end

endmodule

// File: tb/dpram_dual_sync_test.sv
`timescale 1ns/1ps
module dpram_dual_sync_test;

  logic       a_clk = 1'b0, b_clk = 1'b0;
  logic       a_rst_n, b_rst_n;
  logic       a_clken_n, a_ce_n, a_rw, a_oe_n;
  logic       b_clken_n, b_ce_n, b_rw, b_oe_n;
  logic [11:0] a_addr, b_addr;
  logic [8:0]  a_wdata, b_wdata;
  logic [8:0]  a_rdata, b_rdata;
  logic        a_drive, b_drive;

  int checks = 0;
  int failures = 0;
  logic [8:0] model [4096];

  dpram_dual_sync uut (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_clken_n(a_clken_n), .a_ce_n(a_ce_n),
    .a_rw(a_rw), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_clken_n(b_clken_n), .b_ce_n(b_ce_n),
    .b_rw(b_rw), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_drive(b_drive)
  );

  always #5 a_clk = ~a_clk;
  initial begin
    #3;
    forever #5 b_clk = ~b_clk;
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_a(); @(posedge a_clk); #1; endtask
  task automatic tick_b(); @(posedge b_clk); #1; endtask

  task automatic a_idle(); a_ce_n = 1'b1; a_rw = 1'b1; endtask
  task automatic b_idle(); b_ce_n = 1'b1; b_rw = 1'b1; endtask

  task automatic a_write(input logic [11:0] ad, input logic [8:0] d);
    a_clken_n = 1'b0; a_ce_n = 1'b0; a_rw = 1'b0; a_addr = ad; a_wdata = d;
    tick_a(); a_idle(); tick_a();
    model[ad] = d;
  endtask

  task automatic b_write(input logic [11:0] ad, input logic [8:0] d);
    b_clken_n = 1'b0; b_ce_n = 1'b0; b_rw = 1'b0; b_addr = ad; b_wdata = d;
    tick_b(); b_idle(); tick_b();
    model[ad] = d;
  endtask

  task automatic a_read(input logic [11:0] ad, input string req);
    a_clken_n = 1'b0; a_ce_n = 1'b0; a_rw = 1'b1; a_addr = ad;
    tick_a(); a_idle(); tick_a();
    check({req, " a_drive"}, {8'd0, a_drive}, 9'd1);
    check({req, " a_rdata"}, a_rdata, model[ad]);
  endtask

  task automatic b_read(input logic [11:0] ad, input string req);
    b_clken_n = 1'b0; b_ce_n = 1'b0; b_rw = 1'b1; b_addr = ad;
    tick_b(); b_idle(); tick_b();
    check({req, " b_drive"}, {8'd0, b_drive}, 9'd1);
    check({req, " b_rdata"}, b_rdata, model[ad]);
  endtask

  // R8: reset state
  task automatic t_reset();
    check("R8 reset a_drive", {8'd0, a_drive}, 9'd0);
    check("R8 reset b_drive", {8'd0, b_drive}, 9'd0);
    check("R8 reset a_rdata", a_rdata, 9'd0);
  endtask

  // R1 R5 R6: writes and reads on both ports, several patterns and edge addresses
  task automatic t_basic();
    a_write(12'h000, 9'h1FF);
    a_write(12'hFFF, 9'h000);
    a_write(12'h5A5, 9'h0AA);
    b_write(12'h001, 9'h155);
    a_read(12'h000, "R1 a low addr");
    a_read(12'hFFF, "R1 a top addr");
    a_read(12'h5A5, "R6 a mid addr");
    b_read(12'h001, "R1 b own word");
  endtask

  // R9: words cross between ports
  task automatic t_cross();
    a_write(12'h123, 9'h0F0);
    b_read(12'h123, "R9 b sees a write");
    b_write(12'h456, 9'h10F);
    a_read(12'h456, "R9 a sees b write");
    b_write(12'h123, 9'h033);
    a_read(12'h123, "R9 a sees b overwrite");
  endtask

  // R3: held address for a read; held address and data for a write
  task automatic t_hold();
    a_write(12'h01E, 9'h111);
    a_write(12'h028, 9'h0C0);
    a_write(12'h01E, 9'h111);
    a_clken_n = 1'b1; a_ce_n = 1'b0; a_rw = 1'b1; a_addr = 12'h028;
    tick_a(); a_idle(); tick_a();
    check("R3 read uses held addr", a_rdata, 9'h111);
    a_clken_n = 1'b0; a_ce_n = 1'b1; a_addr = 12'h032; a_wdata = 9'h0C3;
    tick_a();
    a_clken_n = 1'b1; a_ce_n = 1'b0; a_rw = 1'b0; a_addr = 12'h03C; a_wdata = 9'h1E1;
    tick_a(); a_idle(); tick_a();
    model[12'h032] = 9'h0C3;
    a_write(12'h03C, 9'h077);
    model[12'h03C] = 9'h077;
    a_clken_n = 1'b1; a_ce_n = 1'b0; a_rw = 1'b0; a_addr = 12'h032; a_wdata = 9'h1E1;
    tick_a(); a_idle(); tick_a();
    model[12'h03C] = 9'h077;
    a_read(12'h03C, "R3 held write reused held data");
    a_read(12'h032, "R3 held write left other addr");
  endtask

  // R2 R4: deselected write stores nothing; deselect drops drive
  task automatic t_deselect();
    a_write(12'h046, 9'h05A);
    a_clken_n = 1'b0; a_ce_n = 1'b1; a_rw = 1'b0; a_addr = 12'h046; a_wdata = 9'h1A5;
    tick_a(); tick_a();
    a_read(12'h046, "R4 deselected write ignored");
    a_clken_n = 1'b0; a_ce_n = 1'b0; a_rw = 1'b1; a_addr = 12'h046;
    tick_a();
    a_ce_n = 1'b1;
    tick_a();
    check("R2 drive after read edge", {8'd0, a_drive}, 9'd1);
    tick_a();
    check("R4 drive low after deselect", {8'd0, a_drive}, 9'd0);
  endtask

  // R6 R7: latency and asynchronous output enable
  task automatic t_oe_latency();
    a_write(12'h050, 9'h13C);
    a_oe_n = 1'b1;
    a_clken_n = 1'b0; a_ce_n = 1'b0; a_rw = 1'b1; a_addr = 12'h050;
    tick_a();
    tick_a();
    check("R7 oe high blocks drive", {8'd0, a_drive}, 9'd0);
    a_oe_n = 1'b0; #1;
    check("R7 oe low drives at once", {8'd0, a_drive}, 9'd1);
    check("R7 data under oe", a_rdata, 9'h13C);
    a_oe_n = 1'b1; #1;
    check("R7 oe high releases at once", {8'd0, a_drive}, 9'd0);
    a_oe_n = 1'b0;
    a_idle(); tick_a(); tick_a();
    a_ce_n = 1'b0; a_rw = 1'b1;
    tick_a();
    check("R6 no drive at capture edge", {8'd0, a_drive}, 9'd0);
    a_idle();
    tick_a();
    check("R6 drive one edge later", {8'd0, a_drive}, 9'd1);
    tick_a();
  endtask

  // R5: read captured the edge right after a write returns the new word
  task automatic t_write_then_read();
    a_write(12'h064, 9'h001);
    a_clken_n = 1'b0; a_ce_n = 1'b0; a_rw = 1'b0; a_addr = 12'h064; a_wdata = 9'h1FE;
    tick_a();
    a_rw = 1'b1;
    tick_a();
    a_idle();
    tick_a();
    check("R5 back-to-back read new word", a_rdata, 9'h1FE);
    model[12'h064] = 9'h1FE;
    b_read(12'h064, "R5 R9 other port new word");
  endtask

  initial begin
    repeat (200000) @(posedge a_clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    a_rst_n = 1'b0; b_rst_n = 1'b0;
    a_clken_n = 1'b0; a_ce_n = 1'b1; a_rw = 1'b1; a_oe_n = 1'b0; a_addr = '0; a_wdata = '0;
    b_clken_n = 1'b0; b_ce_n = 1'b1; b_rw = 1'b1; b_oe_n = 1'b0; b_addr = '0; b_wdata = '0;
    repeat (3) @(posedge a_clk);
    #1;
    t_reset();
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    tick_a(); tick_b();
    t_basic();
    t_cross();
    t_hold();
    t_deselect();
    t_oe_latency();
    t_write_then_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule